// File: doc/BRIEF.md
# Random Bit Collector

This block is the register front end of a hardware random source. A one-bit noise sample enters on `noise_bit` and is captured on a slow sample tick. The tick comes from a programmable divider on the system clock, so the analog source is sampled well under its safe rate. Software sets the divider, turns the generator on and writes the number of bits it wants into a fill counter. Each qualifying tick moves one sample into a 256-bit window, filling it LSB first, and takes one off the counter. Software polls the counter until it reads zero and then reads the window as eight 32-bit words.

The bus is a simple single-cycle 32-bit register port. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. A read returns its data one edge later on `bus_rdata`. The block holds a post-processing mode register for software, but it only ever delivers raw samples. The noise source, health testing and any conditioning are outside the block.

Top module: `entropy_collector`

## Requirements
- R1: After reset every register reads zero: divider, control, post-processing mode, fill count and all eight window words.
- R2: The divider register at offset 0x00 keeps write bits 15:1 as a 15-bit value. It reads back that value in bits 15:1, with bit 0 and bits 31:16 reading zero.
- R3: When the divider value D is non-zero, a sample tick fires once every 2·D clock cycles. When D is zero, no sample is taken.
- R4: The control register at offset 0x20 keeps only bit 31, the generator enable. It reads back with all other bits zero.
- R5: A write to the fill register at offset 0x50 loads the requested bit count, saturating at 256 for any larger value. A read of that register returns the bits still outstanding.
- R6: Each tick with the generator on and a non-zero fill count stores `noise_bit` into the next window bit and lowers the count by one. Bits are stored in this order: bit 0 up to bit 31 of word 0, then word 1, and so on. A new fill write restarts at bit 0 of word 0, and bits it does not reach keep their old values.
- R7: Once the fill count is zero it stays zero and the window stops changing until the next fill write.
- R8: While the generator is off, the fill count and the window hold their values.
- R9: The post-processing register at offset 0x30 stores and reads back write bits 7:0, and its value has no effect on the collected bits.
- R10: Window word i is read at offset 0x80 + 4·i, for i from 0 to 7. Any other offset, including a misaligned one, reads zero.
- R11: Read data appears on `bus_rdata` one clock after the read request, and `bus_rdata` is zero in every cycle that follows a non-read cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the request |
| noise_bit | input | 1 | Raw noise sample |

## Verification
The assertions assume that bus accesses are clean single-cycle requests with `bus_sel` and `bus_wr` at defined levels. They also assume that `noise_bit` carries no unknowns at a sample tick. The bench keeps to this by driving every input at the falling edge from tasks, and by giving `noise_bit` either a held level or an LFSR bit that changes only at falling edges. The bit-ordering checks use held noise levels across fills of different lengths, so the expected words do not depend on which phase the free-running divider is in. The tick-rate check counts over a window of exactly five tick periods, which contains five ticks at any phase.

// File: rtl/ec_pkg.sv
package ec_pkg;

   // register offsets the software map depends on
   localparam logic [7:0] OFS_DIV  = 8'h00;
   localparam logic [7:0] OFS_CTRL = 8'h20;
   localparam logic [7:0] OFS_POST = 8'h30;
   localparam logic [7:0] OFS_FILL = 8'h50;
   localparam logic [7:0] OFS_WIN  = 8'h80;

   localparam int EN_BIT    = 31;
   localparam int BUS_W     = 32;

   // decoded write strobes
   typedef struct packed {
      logic div;
      logic ctrl;
      logic post;
      logic fill;
   } ec_wstb_t;

endpackage

// File: rtl/ec_tick_div.sv
module ec_tick_div #(
   parameter int DIV_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic             restart,
   output logic             tick
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             run;

   assign last = {div_val, 1'b0} - CNT_W'(1);
   assign run  = (div_val != '0);
   assign tick = run && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !run) begin
         cnt_q <= '0;
      end else if (cnt_q == last) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/ec_fill.sv
module ec_fill #(
   parameter int MAX_BITS = 256,
   parameter int CNT_W    = 9,
   parameter int PTR_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fill_wr,
   input  logic [31:0]         wdata,
   input  logic                gen_en,
   input  logic                tick,
   input  logic                noise_bit,
   output logic [CNT_W-1:0]    fill_cnt,
   output logic [MAX_BITS-1:0] window
);
   logic [PTR_W-1:0] ptr_q;
   logic [CNT_W-1:0] load_val;
   logic             take;

   assign load_val = (wdata > 32'(MAX_BITS)) ? CNT_W'(MAX_BITS) : CNT_W'(wdata);
   assign take     = tick && gen_en && (fill_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_cnt <= '0;
         ptr_q    <= '0;
         window   <= '0;
      end else if (fill_wr) begin
         fill_cnt <= load_val;
         ptr_q    <= '0;
      end else if (take) begin
         window[ptr_q] <= noise_bit;
         ptr_q         <= ptr_q + PTR_W'(1);
         fill_cnt      <= fill_cnt - CNT_W'(1);
      end
   end

endmodule

// File: rtl/ec_regs.sv
module ec_regs
   import ec_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DIV_W    = 15,
   parameter int POST_W   = 8,
   parameter int WORDS    = 8,
   parameter int CNT_W    = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [CNT_W-1:0]      fill_cnt,
   input  logic [WORDS*32-1:0]   window,
   output logic [DIV_W-1:0]      div_val,
   output logic                  gen_en,
   output ec_wstb_t              wstb
);
   logic [POST_W-1:0] post_q;
   logic [31:0]       rd_val;
   logic [31:0]       win_word [WORDS];
   logic [WORDS-1:0]  win_hit;

   assign wstb.div  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_DIV));
   assign wstb.ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wstb.post = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_POST));
   assign wstb.fill = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_FILL));

   for (genvar g = 0; g < WORDS; g++) begin : g_win
      assign win_word[g] = window[32*g +: 32];
      assign win_hit[g]  = (bus_addr == ADDR_W'(int'(OFS_WIN) + 4*g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_val <= '0;
         gen_en  <= 1'b0;
         post_q  <= '0;
      end else begin
         if (wstb.div)  div_val <= bus_wdata[DIV_W:1];
         if (wstb.ctrl) gen_en  <= bus_wdata[EN_BIT];
         if (wstb.post) post_q  <= bus_wdata[POST_W-1:0];
      end
   end

   always_comb begin
      rd_val = '0;
      if (bus_addr == ADDR_W'(OFS_DIV))  rd_val = 32'({div_val, 1'b0});
      if (bus_addr == ADDR_W'(OFS_CTRL)) rd_val = 32'(gen_en) << EN_BIT;
      if (bus_addr == ADDR_W'(OFS_POST)) rd_val = 32'(post_q);
      if (bus_addr == ADDR_W'(OFS_FILL)) rd_val = 32'(fill_cnt);
      for (int i = 0; i < WORDS; i++) begin
         if (win_hit[i]) rd_val = win_word[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 bus_rdata <= '0;
      else if (bus_sel && !bus_wr) bus_rdata <= rd_val;
      else                         bus_rdata <= '0;
   end

endmodule

// File: rtl/entropy_collector.sv
module entropy_collector
   import ec_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DIV_W  = 15,
   parameter int POST_W = 8,
   parameter int WORDS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              noise_bit
);
   localparam int MAX_BITS = WORDS * 32;
   localparam int CNT_W    = $clog2(MAX_BITS + 1);
   localparam int PTR_W    = $clog2(MAX_BITS);

   if (WORDS < 1) begin : g_bad_words
      $error("WORDS must be at least 1");
   end
   if (DIV_W < 1 || DIV_W > 30) begin : g_bad_div
      $error("DIV_W must lie in 1..30");
   end
   if (POST_W < 1 || POST_W > 32) begin : g_bad_post
      $error("POST_W must lie in 1..32");
   end
   if (int'(OFS_WIN) + 4*WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("window does not fit in the address space");
   end

   logic [DIV_W-1:0]    div_val;
   logic                gen_en;
   ec_wstb_t            wstb;
   logic                tick;
   logic                fill_wr;
   logic [CNT_W-1:0]    fill_cnt;
   logic [MAX_BITS-1:0] window;

   assign fill_wr = wstb.fill;

   ec_regs #(
      .ADDR_W(ADDR_W), .DIV_W(DIV_W), .POST_W(POST_W),
      .WORDS(WORDS), .CNT_W(CNT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fill_cnt(fill_cnt), .window(window),
      .div_val(div_val), .gen_en(gen_en), .wstb(wstb)
   );

   ec_tick_div #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n),
      .div_val(div_val), .restart(wstb.div), .tick(tick)
   );

   ec_fill #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_fill (
      .clk(clk), .rst_n(rst_n),
      .fill_wr(fill_wr), .wdata(bus_wdata),
      .gen_en(gen_en), .tick(tick), .noise_bit(noise_bit),
      .fill_cnt(fill_cnt), .window(window)
   );

endmodule

// File: rtl/ec_checker.sv
module ec_checker #(
   parameter int MAX_BITS = 256,
   parameter int CNT_W    = 9,
   parameter int DIV_W    = 15
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_sel,
   input logic                bus_wr,
   input logic [31:0]         bus_rdata,
   input logic                fill_wr,
   input logic                gen_en,
   input logic                tick,
   input logic [DIV_W-1:0]    div_val,
   input logic [CNT_W-1:0]    fill_cnt,
   input logic [MAX_BITS-1:0] window
);

   p_fill_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CNT_W'(MAX_BITS));

   p_take_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && gen_en && fill_cnt != '0 && !fill_wr) |=> fill_cnt == $past(fill_cnt) - CNT_W'(1));

   p_done_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_cnt == '0 && !fill_wr) |=> (fill_cnt == '0) && $stable(window));

   p_off_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_en && !fill_wr) |=> $stable(fill_cnt) && $stable(window));

   p_div_zero_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (div_val == '0) |-> !tick);

   p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |=> bus_rdata == '0);

endmodule

bind entropy_collector ec_checker #(
   .MAX_BITS(MAX_BITS), .CNT_W(CNT_W), .DIV_W(DIV_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_rdata(bus_rdata), .fill_wr(fill_wr), .gen_en(gen_en),
   .tick(tick), .div_val(div_val), .fill_cnt(fill_cnt), .window(window)
);

// File: tb/entropy_collector_bench.sv
module entropy_collector_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        noise_bit;
   logic        noise_lvl = 1'b0;
   logic        lfsr_on = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   always @(negedge clk) if (lfsr_on)
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

   assign noise_bit = lfsr_on ? lfsr[0] : noise_lvl;

   entropy_collector u_entropy_collector (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .noise_bit(noise_bit)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic read_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      bus_read(a, v);
      check(tag, v, exp);
   endtask

   task automatic wait_done(input string tag);
      logic [31:0] v;
      v = 32'hFFFF_FFFF;
      for (int n = 0; n < 3000 && v != 0; n++) bus_read(8'h50, v);
      check(tag, v, 32'h0);
   endtask

   task automatic t_reset;
      check("R11 idle rdata after reset", bus_rdata, 32'h0);
      read_check("R1 divider", 8'h00, 32'h0);
      read_check("R1 control", 8'h20, 32'h0);
      read_check("R1 post", 8'h30, 32'h0);
      read_check("R1 fill", 8'h50, 32'h0);
      read_check("R1 word0", 8'h80, 32'h0);
      read_check("R1 word7", 8'h9C, 32'h0);
   endtask

   task automatic t_regs;
      bus_write(8'h00, 32'hFFFF_FFFF);
      read_check("R2 divider field", 8'h00, 32'h0000_FFFE);
      bus_write(8'h00, 32'h0000_0006);
      read_check("R2 divider small", 8'h00, 32'h0000_0006);
      bus_write(8'h20, 32'hFFFF_FFFF);
      read_check("R4 enable only", 8'h20, 32'h8000_0000);
      bus_write(8'h20, 32'h7FFF_FFFF);
      read_check("R4 enable cleared", 8'h20, 32'h0);
      bus_write(8'h30, 32'h0000_01A5);
      read_check("R9 post low byte", 8'h30, 32'h0000_00A5);
      bus_write(8'h30, 32'h0);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      read_check("R10 offset 0x10", 8'h10, 32'h0);
      read_check("R10 offset 0xA0", 8'hA0, 32'h0);
      read_check("R10 misaligned 0x81", 8'h81, 32'h0);
      bus_read(8'hFC, v);
      check("R10 offset 0xFC", v, 32'h0);
      check("R11 rdata zero after read", bus_rdata, 32'h0);
   endtask

   task automatic t_saturate;
      bus_write(8'h20, 32'h0);
      bus_write(8'h50, 32'd1000);
      read_check("R5 saturate 1000", 8'h50, 32'd256);
      bus_write(8'h50, 32'h8000_0000);
      read_check("R5 saturate top bit", 8'h50, 32'd256);
      bus_write(8'h50, 32'd7);
      read_check("R5 small load", 8'h50, 32'd7);
   endtask

   task automatic t_hold;
      bus_write(8'h00, 32'h2);
      bus_write(8'h20, 32'h0);
      bus_write(8'h50, 32'd40);
      noise_lvl = 1'b1;
      repeat (200) @(negedge clk);
      read_check("R8 count held", 8'h50, 32'd40);
      read_check("R8 window held", 8'h80, 32'h0);
   endtask

   task automatic t_div_zero;
      bus_write(8'h00, 32'h0);
      bus_write(8'h20, 32'h8000_0000);
      bus_write(8'h50, 32'd12);
      repeat (100) @(negedge clk);
      read_check("R3 divider zero stops sampling", 8'h50, 32'd12);
   endtask

   task automatic t_rate;
      bus_write(8'h00, 32'h6);            // D = 3, tick every 6 clocks
      bus_write(8'h20, 32'h8000_0000);
      bus_write(8'h50, 32'd10);
      repeat (30) @(negedge clk);         // 30 edges => exactly 5 ticks
      read_check("R3 five ticks in thirty clocks", 8'h50, 32'd5);
      wait_done("R3 rate fill completes");
   endtask

   task automatic t_pattern;
      bus_write(8'h00, 32'h2);            // D = 1
      bus_write(8'h20, 32'h8000_0000);
      noise_lvl = 1'b1;
      bus_write(8'h50, 32'd256);
      wait_done("R6 full fill done");
      for (int i = 0; i < 8; i++)
         read_check("R6 all ones", 8'(8'h80 + 4*i), 32'hFFFF_FFFF);
      noise_lvl = 1'b0;
      bus_write(8'h30, 32'h3C);
      bus_write(8'h50, 32'd24);
      wait_done("R6 partial fill done");
      read_check("R6 R9 restart low bits first", 8'h80, 32'hFF00_0000);
      read_check("R6 untouched word kept", 8'h84, 32'hFFFF_FFFF);
      bus_write(8'h30, 32'h0);
      bus_write(8'h50, 32'd256);
      wait_done("R6 clear fill done");
      read_check("R6 word3 zero", 8'h8C, 32'h0);
      noise_lvl = 1'b1;
      bus_write(8'h50, 32'd40);
      wait_done("R6 span fill done");
      read_check("R6 span word0", 8'h80, 32'hFFFF_FFFF);
      read_check("R6 span word1", 8'h84, 32'h0000_00FF);
      read_check("R6 span word2", 8'h88, 32'h0);
   endtask

   task automatic t_done_stable;
      noise_lvl = 1'b0;
      repeat (100) @(negedge clk);
      read_check("R7 count stays zero", 8'h50, 32'h0);
      read_check("R7 window unchanged word0", 8'h80, 32'hFFFF_FFFF);
      read_check("R7 window unchanged word1", 8'h84, 32'h0000_00FF);
   endtask

   task automatic t_lfsr;
      logic [31:0] v;
      logic [31:0] any_one;
      logic [31:0] all_one;
      any_one = '0;
      all_one = '1;
      lfsr_on = 1'b1;
      bus_write(8'h50, 32'd256);
      wait_done("R7 noise fill completes");
      lfsr_on = 1'b0;
      for (int i = 0; i < 8; i++) begin
         bus_read(8'(8'h80 + 4*i), v);
         any_one |= v;
         all_one &= v;
      end
      check("R6 noise window has ones", 32'(any_one != 0), 32'h1);
      check("R6 noise window has zeros", 32'(all_one != 32'hFFFF_FFFF), 32'h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_unmapped();
      t_saturate();
      t_hold();
      t_div_zero();
      t_rate();
      t_pattern();
      t_done_stable();
      t_lfsr();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule